// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block chooses the power mode a small processor subsystem moves into when its core executes a stop instruction. It also holds the current mode until a wake-up event returns it to run. The core supplies a one-cycle stop strobe and a set of configuration bits. The bits select wait or stop behaviour, choose how an illegal stop is reported, and ask for the reduced-regulation modes. A bus-slow flag from clock generation and a debug-in-low-power enable decide whether loose regulation or partial power-down is allowed.

Only five modes exist: run, wait, fully regulated stop, standby and partial power-down. The regulator-standby output and the logic-power-off output drive the power switching outside the block, and the 3-bit mode code makes the state visible. All outputs are registered. Each one changes on the clock edge that samples the inputs causing the change.

Top module: `lpmode_ctrl`

## Requirements
- R1: A stop strobe in run with the wait enable set puts the mode code to 1 (wait) on the next edge, even when the stop enable is also set.
- R2: A stop strobe in run with the wait enable clear and the stop enable set, and no reduced mode allowed, gives mode code 2 (stop) with both power controls low.
- R3: A stop strobe in run with both enables clear and the exception-select bit clear raises the reset request for exactly one cycle. The mode stays 0 (run).
- R4: The same illegal strobe with the exception-select bit set raises the illegal-instruction pulse for exactly one cycle. The reset request stays low.
- R5: A legal stop-class strobe with the partial-off select set gives mode code 4, with both regulator standby and logic power off high.
- R6: With the standby request set and the bus-slow flag high, run moves to mode code 3 (standby) without any strobe. Regulator standby goes high and logic power off stays low.
- R7: A standby request while the bus-slow flag is low is ignored. The block stays in run with regulator standby low.
- R8: While debug-in-low-power is set, neither standby nor partial power-down is entered, and a stop-class strobe gives mode 2.
- R9: When partial-off select and standby request are set together, the error output is high one edge later, and no reduced-power mode is entered.
- R10: In any mode other than run, strobes and requests are ignored. The mode holds, and no reset request or exception pulse appears, until a wake-up event arrives.
- R11: A wake-up event in modes 1 to 4 returns the mode to 0 on the next edge and clears both power controls.
- R12: While the active-low asynchronous reset is asserted, the mode is 0 and every output is low.
- R13: A legal stop-class strobe with the standby request set, the bus-slow flag high and partial-off clear gives mode 3. A wake-up event in run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopStrobe | input | 1 | One-cycle stop-instruction strobe |
| cfgWaitEn | input | 1 | Stop strobe selects wait mode |
| cfgStopEn | input | 1 | Stop strobe selects a stop-class mode |
| cfgIllegalExc | input | 1 | Illegal stop raises an exception instead of reset |
| cfgPartialOff | input | 1 | Stop-class entry goes to partial power-down |
| cfgStandbyReq | input | 1 | Request loose-regulation standby |
| cfgDebugLp | input | 1 | Debug active in low power; blocks reduced modes |
| busSlow | input | 1 | Bus clock is slow enough for standby |
| wakeEvent | input | 1 | Wake-up event; returns to run |
| modeState | output | 3 | 0 run, 1 wait, 2 stop, 3 standby, 4 partial off |
| regStandby | output | 1 | Regulator in standby |
| logicOff | output | 1 | Digital logic powered off |
| resetReq | output | 1 | Reset request pulse after illegal stop |
| illegalExc | output | 1 | Illegal-instruction exception pulse |
| cfgError | output | 1 | Partial-off and standby requested together |

## Verification
The bench sets the wait and stop enables together to catch a design that gives stop priority over wait and lands in mode 2. It sends illegal strobes with each setting of the exception-select bit, so a swapped or sticky report shows up as the wrong pulse or as a pulse lasting two cycles. It sends reduced-mode requests with the bus fast, with debug enabled and with the conflicting configuration. A design that misses any of these guards shows regulator standby high or mode 3 or 4. It also fires strobes and requests inside every low-power mode, so a design that switches between low-power modes changes its mode code where it must hold.

// File: rtl/lpmode_pkg.sv
package lpmode_pkg;
  parameter int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN     = 3'd0,
    MODE_WAIT    = 3'd1,
    MODE_STOP    = 3'd2,
    MODE_STANDBY = 3'd3,
    MODE_PARTOFF = 3'd4
  } mode_e;

  typedef struct packed {
    logic  load;
    mode_e nextMode;
    logic  pulseReset;
    logic  pulseExc;
  } lpStrobes_t;
endpackage

// File: rtl/lpmode_decide.sv
module lpmode_decide
  import lpmode_pkg::*;
(
  input  mode_e      curMode,
  input  logic       stopStrobe,
  input  logic       cfgWaitEn,
  input  logic       cfgStopEn,
  input  logic       cfgIllegalExc,
  input  logic       cfgPartialOff,
  input  logic       cfgStandbyReq,
  input  logic       cfgDebugLp,
  input  logic       busSlow,
  input  logic       wakeEvent,
  output lpStrobes_t stb
);
  logic reducedOk;
  logic standbyOk;

  // Reduced regulation is blocked by debug and by the conflicting request pair.
  assign reducedOk = !cfgDebugLp && !(cfgPartialOff && cfgStandbyReq);
  assign standbyOk = reducedOk && cfgStandbyReq && busSlow;

  always_comb begin
    stb = '0;
    stb.nextMode = MODE_RUN;
    if (curMode == MODE_RUN) begin
      if (stopStrobe) begin
        if (cfgWaitEn) begin
          stb.load     = 1'b1;
          stb.nextMode = MODE_WAIT;
        end else if (cfgStopEn) begin
          stb.load = 1'b1;
          if (reducedOk && cfgPartialOff) begin
            stb.nextMode = MODE_PARTOFF;
          end else if (standbyOk) begin
            stb.nextMode = MODE_STANDBY;
          end else begin
            stb.nextMode = MODE_STOP;
          end
        end else if (cfgIllegalExc) begin
          stb.pulseExc = 1'b1;
        end else begin
          stb.pulseReset = 1'b1;
        end
      end else if (standbyOk) begin
        stb.load     = 1'b1;
        stb.nextMode = MODE_STANDBY;
      end
    end else if (wakeEvent) begin
      stb.load     = 1'b1;
      stb.nextMode = MODE_RUN;
    end
  end
endmodule

// File: rtl/lpmode_datapath.sv
module lpmode_datapath
  import lpmode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lpStrobes_t stb,
  input  logic       cfgPartialOff,
  input  logic       cfgStandbyReq,
  output mode_e      curMode,
  output logic       regStandby,
  output logic       logicOff,
  output logic       resetReq,
  output logic       illegalExc,
  output logic       cfgError
);
  logic nextRegStby;
  logic nextOff;

  assign nextRegStby = (stb.nextMode == MODE_STANDBY) || (stb.nextMode == MODE_PARTOFF);
  assign nextOff     = (stb.nextMode == MODE_PARTOFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode    <= MODE_RUN;
      regStandby <= 1'b0;
      logicOff   <= 1'b0;
      resetReq   <= 1'b0;
      illegalExc <= 1'b0;
      cfgError   <= 1'b0;
    end else begin
      if (stb.load) begin
        curMode    <= stb.nextMode;
        regStandby <= nextRegStby;
        logicOff   <= nextOff;
      end
      resetReq   <= stb.pulseReset;
      illegalExc <= stb.pulseExc;
      cfgError   <= cfgPartialOff && cfgStandbyReq;
    end
  end
endmodule

// File: rtl/lpmode_ctrl.sv
module lpmode_ctrl
  import lpmode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopStrobe,
  input  logic              cfgWaitEn,
  input  logic              cfgStopEn,
  input  logic              cfgIllegalExc,
  input  logic              cfgPartialOff,
  input  logic              cfgStandbyReq,
  input  logic              cfgDebugLp,
  input  logic              busSlow,
  input  logic              wakeEvent,
  output logic [MODE_W-1:0] modeState,
  output logic              regStandby,
  output logic              logicOff,
  output logic              resetReq,
  output logic              illegalExc,
  output logic              cfgError
);
  mode_e      curMode;
  lpStrobes_t stb;

  lpmode_decide u_decide (
    .curMode      (curMode),
    .stopStrobe   (stopStrobe),
    .cfgWaitEn    (cfgWaitEn),
    .cfgStopEn    (cfgStopEn),
    .cfgIllegalExc(cfgIllegalExc),
    .cfgPartialOff(cfgPartialOff),
    .cfgStandbyReq(cfgStandbyReq),
    .cfgDebugLp   (cfgDebugLp),
    .busSlow      (busSlow),
    .wakeEvent    (wakeEvent),
    .stb          (stb)
  );

  lpmode_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cfgPartialOff(cfgPartialOff),
    .cfgStandbyReq(cfgStandbyReq),
    .curMode      (curMode),
    .regStandby   (regStandby),
    .logicOff     (logicOff),
    .resetReq     (resetReq),
    .illegalExc   (illegalExc),
    .cfgError     (cfgError)
  );

  assign modeState = curMode;
endmodule

// File: rtl/lpmode_checker.sv
module lpmode_checker (
  input logic       clk,
  input logic       rstN,
  input logic       stopStrobe,
  input logic       cfgWaitEn,
  input logic       cfgDebugLp,
  input logic       busSlow,
  input logic       wakeEvent,
  input logic [2:0] modeState,
  input logic       regStandby,
  input logic       logicOff,
  input logic       resetReq,
  input logic       illegalExc
);
  a_r1_wait_first: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 3'd0 && stopStrobe && cfgWaitEn) |=> modeState == 3'd1);

  a_r3_reset_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  a_r4_exc_pulse: assert property (@(posedge clk) disable iff (!rstN)
    illegalExc |=> !illegalExc);

  a_r4_one_report: assert property (@(posedge clk) disable iff (!rstN)
    !(resetReq && illegalExc));

  a_r5_off_needs_stby: assert property (@(posedge clk) disable iff (!rstN)
    logicOff |-> (regStandby && modeState == 3'd4));

  a_r7_fast_bus: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 3'd0 && !busSlow) |=> modeState != 3'd3);

  a_r8_debug_block: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 3'd0 && cfgDebugLp) |=> !regStandby);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (modeState != 3'd0 && !wakeEvent) |=> $stable(modeState));

  a_r11_wake: assert property (@(posedge clk) disable iff (!rstN)
    (modeState != 3'd0 && wakeEvent) |=> (modeState == 3'd0 && !regStandby && !logicOff));
endmodule

bind lpmode_ctrl lpmode_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stopStrobe(stopStrobe),
  .cfgWaitEn (cfgWaitEn),
  .cfgDebugLp(cfgDebugLp),
  .busSlow   (busSlow),
  .wakeEvent (wakeEvent),
  .modeState (modeState),
  .regStandby(regStandby),
  .logicOff  (logicOff),
  .resetReq  (resetReq),
  .illegalExc(illegalExc)
);

// File: tb/tb_lpmode_ctrl.sv
module tb_lpmode_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopStrobe = 0, cfgWaitEn = 0, cfgStopEn = 0, cfgIllegalExc = 0;
  logic cfgPartialOff = 0, cfgStandbyReq = 0, cfgDebugLp = 0, busSlow = 0, wakeEvent = 0;
  logic [2:0] modeState;
  logic regStandby, logicOff, resetReq, illegalExc, cfgError;

  int testsRun = 0;
  int testsFailed = 0;

  typedef struct {
    logic [2:0] mode;
    logic rs, lo, rr, ex, er;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t cur;

  always #4 clk = ~clk;

  lpmode_ctrl dut (
    .clk(clk), .rstN(rstN), .stopStrobe(stopStrobe), .cfgWaitEn(cfgWaitEn),
    .cfgStopEn(cfgStopEn), .cfgIllegalExc(cfgIllegalExc), .cfgPartialOff(cfgPartialOff),
    .cfgStandbyReq(cfgStandbyReq), .cfgDebugLp(cfgDebugLp), .busSlow(busSlow),
    .wakeEvent(wakeEvent), .modeState(modeState), .regStandby(regStandby),
    .logicOff(logicOff), .resetReq(resetReq), .illegalExc(illegalExc), .cfgError(cfgError)
  );

  task automatic checkVal(string tag, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clearIn();
    stopStrobe = 0; cfgWaitEn = 0; cfgStopEn = 0; cfgIllegalExc = 0;
    cfgPartialOff = 0; cfgStandbyReq = 0; cfgDebugLp = 0; busSlow = 0; wakeEvent = 0;
  endtask

  // Driver half: called right after inputs are set at a falling edge.
  task automatic expectNext(logic [2:0] m, logic rs, logic lo, logic rr, logic ex,
                            logic er, string tag);
    expItem_t it;
    it.mode = m; it.rs = rs; it.lo = lo; it.rr = rr; it.ex = ex; it.er = er; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares the item for the edge that just sampled it.
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      cur = expQ.pop_front();
      checkVal(cur.tag, "mode", int'(modeState), int'(cur.mode));
      checkVal(cur.tag, "regStandby", int'(regStandby), int'(cur.rs));
      checkVal(cur.tag, "logicOff", int'(logicOff), int'(cur.lo));
      checkVal(cur.tag, "resetReq", int'(resetReq), int'(cur.rr));
      checkVal(cur.tag, "illegalExc", int'(illegalExc), int'(cur.ex));
      checkVal(cur.tag, "cfgError", int'(cfgError), int'(cur.er));
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R12: reset state, with inputs that would otherwise cause activity
    #6;
    stopStrobe = 1;
    #10;
    checkVal("R12", "mode", int'(modeState), 0);
    checkVal("R12", "outputs", int'({regStandby, logicOff, resetReq, illegalExc, cfgError}), 0);
    stopStrobe = 0;
    @(negedge clk); rstN = 1;

    @(negedge clk); clearIn(); expectNext(3'd0, 0, 0, 0, 0, 0, "R12");

    // R1 wait wins over stop
    @(negedge clk); cfgWaitEn = 1; cfgStopEn = 1; stopStrobe = 1;
    expectNext(3'd1, 0, 0, 0, 0, 0, "R1");
    @(negedge clk); clearIn(); expectNext(3'd1, 0, 0, 0, 0, 0, "R10");
    @(negedge clk); cfgStopEn = 1; cfgPartialOff = 1; stopStrobe = 1;
    expectNext(3'd1, 0, 0, 0, 0, 0, "R10");
    @(negedge clk); clearIn(); wakeEvent = 1; expectNext(3'd0, 0, 0, 0, 0, 0, "R11");

    // R2 plain stop
    @(negedge clk); clearIn(); cfgStopEn = 1; stopStrobe = 1;
    expectNext(3'd2, 0, 0, 0, 0, 0, "R2");
    @(negedge clk); clearIn(); stopStrobe = 1; expectNext(3'd2, 0, 0, 0, 0, 0, "R10");
    @(negedge clk); clearIn(); wakeEvent = 1; expectNext(3'd0, 0, 0, 0, 0, 0, "R11");

    // R3 illegal stop -> reset request pulse
    @(negedge clk); clearIn(); stopStrobe = 1; expectNext(3'd0, 0, 0, 1, 0, 0, "R3");
    @(negedge clk); clearIn(); expectNext(3'd0, 0, 0, 0, 0, 0, "R3");

    // R4 illegal stop -> exception pulse
    @(negedge clk); clearIn(); cfgIllegalExc = 1; stopStrobe = 1;
    expectNext(3'd0, 0, 0, 0, 1, 0, "R4");
    @(negedge clk); stopStrobe = 0; expectNext(3'd0, 0, 0, 0, 0, 0, "R4");

    // R5 partial power-down
    @(negedge clk); clearIn(); cfgStopEn = 1; cfgPartialOff = 1; stopStrobe = 1;
    expectNext(3'd4, 1, 1, 0, 0, 0, "R5");
    @(negedge clk); clearIn(); cfgStandbyReq = 1; busSlow = 1;
    expectNext(3'd4, 1, 1, 0, 0, 0, "R10");
    @(negedge clk); clearIn(); stopStrobe = 1; expectNext(3'd4, 1, 1, 0, 0, 0, "R10");
    @(negedge clk); clearIn(); wakeEvent = 1; expectNext(3'd0, 0, 0, 0, 0, 0, "R11");

    // R6 standby without strobe
    @(negedge clk); clearIn(); cfgStandbyReq = 1; busSlow = 1;
    expectNext(3'd3, 1, 0, 0, 0, 0, "R6");
    @(negedge clk); cfgWaitEn = 1; stopStrobe = 1; expectNext(3'd3, 1, 0, 0, 0, 0, "R10");
    @(negedge clk); clearIn(); cfgStopEn = 1; cfgPartialOff = 1; stopStrobe = 1;
    expectNext(3'd3, 1, 0, 0, 0, 0, "R10");
    @(negedge clk); clearIn(); wakeEvent = 1; expectNext(3'd0, 0, 0, 0, 0, 0, "R11");

    // R7 bus too fast
    @(negedge clk); clearIn(); cfgStandbyReq = 1; expectNext(3'd0, 0, 0, 0, 0, 0, "R7");
    @(negedge clk); expectNext(3'd0, 0, 0, 0, 0, 0, "R7");

    // R8 debug blocks reduced modes
    @(negedge clk); clearIn(); cfgDebugLp = 1; cfgStandbyReq = 1; busSlow = 1;
    expectNext(3'd0, 0, 0, 0, 0, 0, "R8");
    @(negedge clk); clearIn(); cfgDebugLp = 1; cfgStopEn = 1; cfgPartialOff = 1; stopStrobe = 1;
    expectNext(3'd2, 0, 0, 0, 0, 0, "R8");
    @(negedge clk); clearIn(); wakeEvent = 1; expectNext(3'd0, 0, 0, 0, 0, 0, "R11");

    // R9 conflicting configuration
    @(negedge clk); clearIn(); cfgPartialOff = 1; cfgStandbyReq = 1; busSlow = 1;
    expectNext(3'd0, 0, 0, 0, 0, 1, "R9");
    @(negedge clk); cfgStopEn = 1; stopStrobe = 1; expectNext(3'd2, 0, 0, 0, 0, 1, "R9");
    @(negedge clk); clearIn(); wakeEvent = 1; expectNext(3'd0, 0, 0, 0, 0, 0, "R9");

    // R13 standby through a stop strobe, then wake in run
    @(negedge clk); clearIn(); cfgStopEn = 1; cfgStandbyReq = 1; busSlow = 1; stopStrobe = 1;
    expectNext(3'd3, 1, 0, 0, 0, 0, "R13");
    @(negedge clk); clearIn(); wakeEvent = 1; expectNext(3'd0, 0, 0, 0, 0, 0, "R11");
    @(negedge clk); expectNext(3'd0, 0, 0, 0, 0, 0, "R13");
    @(negedge clk); clearIn(); expectNext(3'd0, 0, 0, 0, 0, 0, "R13");

    @(negedge clk);
    @(negedge clk);
    checkVal("R10", "queue drained", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule